// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It walks a context table and up to three levels of page tables in memory. A request carries the virtual address and a write flag. Three configuration inputs steer the walk: the translation enable, the context-table root pointer and the current context number.

The walker reads one 32-bit entry at a time through a simple memory port and classifies each entry by its two type bits. It either descends to the next table, stops on a leaf entry, or stops with a fault code. The fault code names the level reached and the kind of fault. When a leaf is found, the walker sets the leaf's accessed bit, and its modified bit on a write. It writes the entry back to memory only if one of those bits actually changed.

The results are the physical address, the leaf entry and the level at which the leaf sat, or the fault code. A later stage sizes the mapping from the leaf level. The results stay on the outputs until the next request is taken.

Top module: `pgw_top`

## Requirements
- R1: While `mmu_on` is low, an accepted request completes with `done` in the following cycle. It reports `paddr` equal to the zero-extended virtual address, `leaf_level` 0 and `fault_code` 0, and issues no memory request.
- R2: With translation on, the first memory read of a walk is at address (`ctx_root` << 4) + (`ctx_id` << 2).
- R3: Bits [1:0] of each fetched entry give its kind: 0 invalid, 1 table pointer, 2 leaf, 3 reserved. After a table pointer at context level, level 1 or level 2, the next read is at ((entry with bits [1:0] cleared) << 4) plus an index. The index is VA[31:24]*4 for the level-1 table, VA[23:18]*4 for the level-2 table and VA[17:12]*4 for the level-3 table. A walk makes at most four reads.
- R4: A leaf at level 1 maps 16 MB with offset VA[23:0], a leaf at level 2 maps 256 KB with offset VA[17:0], and a leaf at level 3 maps 4 KB with offset VA[11:0]. `paddr` = (entry[31:8] << 12) + offset, and `leaf_level` gives the level (1, 2 or 3).
- R5: `fault_code` carries the walk level (0 = context entry, 1 to 3 = table levels) in bits [9:8] and the fault type in bits [4:2], with all other bits zero. An invalid entry gives type 1.
- R6: Type 4 (translation error) is reported for a reserved entry at any level, a leaf in the context entry, and a table pointer at level 3.
- R7: On a leaf, bit 5 (accessed) is set, and on a write bit 6 (modified) is also set. The updated entry is written to the address the leaf was read from, and `leaf_entry` shows the updated entry.
- R8: No write-back occurs when the accessed bit, and for a write also the modified bit, are already set. No write-back occurs on a fault or in bypass.
- R9: A memory request stays valid with a stable address until `mem_req_ready`. At most one read is outstanding. A read completes on its single `mem_rsp_valid` beat, and a write completes when it is accepted.
- R10: `req_ready` is high only while idle. `done` is a one-cycle pulse. The result outputs hold their values until the next request is accepted.
- R11: After reset, `req_ready` is high, and `done` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request is taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| mmu_on | input | 1 | Translation enable |
| ctx_root | input | 32 | Context-table root pointer |
| ctx_id | input | CTX_W | Current context number |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 36 | Memory byte address |
| mem_req_wdata | output | 32 | Write data (updated leaf) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | Walk complete pulse |
| paddr | output | 36 | Physical address |
| leaf_entry | output | 32 | Leaf entry after bit update |
| leaf_level | output | 2 | Level where the leaf was found |
| fault_code | output | 10 | Fault level and type, 0 if none |

## Verification
The assertions rely on the memory side answering only reads the walker has issued, with exactly one response beat per accepted read. They also rely on `mmu_on`, `ctx_root` and `ctx_id` staying steady for the length of a walk. The bench's memory model returns data only in the cycle after it accepts a read, and it flags any request that overlaps a pending response. The bench changes configuration and request inputs only while the walker is idle. The model also withholds `mem_req_ready` on a fixed cadence, so that every walk crosses stalled cycles and the hold-until-accepted rule is exercised.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int VA_W   = 32;
  localparam int ENT_W  = 32;
  localparam int PA_W   = VA_W + 4;
  localparam int FLT_W  = 10;
  localparam int ACC_BIT = 5;
  localparam int MOD_BIT = 6;
  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_XLATE   = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_CTX, ST_FETCH_L1, ST_FETCH_L2, ST_FETCH_L3, ST_UPDATE, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    EK_INVALID = 2'd0, EK_TABLE = 2'd1, EK_LEAF = 2'd2, EK_RESERVED = 2'd3
  } entry_kind_e;

  typedef enum logic [1:0] { ACT_DESCEND, ACT_LEAF, ACT_FAULT } step_act_e;

  // Address of the context slot: root scaled by 16 plus context scaled by 4.
  function automatic logic [PA_W-1:0] ctx_slot_addr(input logic [VA_W-1:0] root,
                                                    input logic [VA_W-1:0] ctx);
    return {root, 4'b0000} + PA_W'({ctx, 2'b00});
  endfunction

  // Read address inside the table a pointer entry selects, for the level being entered.
  function automatic logic [PA_W-1:0] table_addr(input logic [ENT_W-1:0] ent,
                                                 input logic [VA_W-1:0] va,
                                                 input logic [1:0] nlvl);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] idx;
    base = {ent[ENT_W-1:2], 2'b00, 4'b0000};
    case (nlvl)
      2'd1:    idx = PA_W'({va[31:24], 2'b00});
      2'd2:    idx = PA_W'({va[23:18], 2'b00});
      default: idx = PA_W'({va[17:12], 2'b00});
    endcase
    return base + idx;
  endfunction

  // Physical address from a leaf entry; the page size follows the leaf level.
  function automatic logic [PA_W-1:0] leaf_paddr(input logic [ENT_W-1:0] ent,
                                                 input logic [VA_W-1:0] va,
                                                 input logic [1:0] lvl);
    logic [PA_W-1:0] off;
    case (lvl)
      2'd1:    off = PA_W'(va[23:0]);
      2'd2:    off = PA_W'(va[17:0]);
      default: off = PA_W'(va[11:0]);
    endcase
    return {ent[ENT_W-1:8], 12'h000} + off;
  endfunction

  function automatic logic [FLT_W-1:0] fault_word(input logic [1:0] lvl, input logic [2:0] ft);
    return {lvl, 3'b000, ft, 2'b00};
  endfunction
endpackage

// File: rtl/pgw_step.sv
module pgw_step
  import pgw_pkg::*;
(
  input  entry_kind_e kind,
  input  logic [1:0]  lvl,
  output step_act_e   act,
  output logic [2:0]  ftype
);
  always_comb begin
    act   = ACT_FAULT;
    ftype = FT_XLATE;
    case (kind)
      EK_INVALID:  ftype = FT_INVALID;
      EK_TABLE:    if (lvl != 2'd3) act = ACT_DESCEND;
      EK_LEAF:     if (lvl != 2'd0) act = ACT_LEAF;
      default:     ftype = FT_XLATE;
    endcase
  end
endmodule

// File: rtl/pgw_memif.sv
module pgw_memif #(
  parameter int AW = 36,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_done,
  output logic [DW-1:0] cmd_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  logic pend;
  logic req_fire;
  logic rsp_take;

  assign mem_req_valid = cmd_go && !pend;
  assign mem_req_write = cmd_write;
  assign mem_req_addr  = cmd_addr;
  assign mem_req_wdata = cmd_wdata;
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign rsp_take      = pend && mem_rsp_valid;
  assign cmd_done      = (req_fire && cmd_write) || rsp_take;
  assign cmd_rdata     = mem_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pend <= 1'b0;
    else if (req_fire && !cmd_write) pend <= 1'b1;
    else if (rsp_take)              pend <= 1'b0;
  end

  // R9: a stalled request keeps its address and direction until accepted
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R9: after a read is taken, no new request until its response arrives
  a_r9_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !cmd_write) |=> !mem_req_valid);
endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic                req_write,
  input  logic                mmu_on,
  input  logic [VA_W-1:0]     ctx_root,
  input  logic [CTX_W-1:0]    ctx_id,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [PA_W-1:0]     mem_req_addr,
  output logic [ENT_W-1:0]    mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [ENT_W-1:0]    mem_rsp_data,
  output logic                done,
  output logic [PA_W-1:0]     paddr,
  output logic [ENT_W-1:0]    leaf_entry,
  output logic [1:0]          leaf_level,
  output logic [FLT_W-1:0]    fault_code
);
  walk_state_e      st;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  paddr_q;
  logic [ENT_W-1:0] leaf_q;
  logic [1:0]       lvl_q;
  logic [FLT_W-1:0] flt_q;

  logic             cmd_go, cmd_write, cmd_done;
  logic [ENT_W-1:0] rdata;
  logic [1:0]       cur_lvl;
  logic             in_fetch;
  step_act_e        act;
  logic [2:0]       ftype;
  logic [ENT_W-1:0] upd_ent;

  // named events for the checks below
  logic walk_accept, walk_bypass, step_done, step_leaf, step_fault, leaf_needs_wb;

  function automatic walk_state_e next_fetch(input walk_state_e s);
    case (s)
      ST_FETCH_CTX: return ST_FETCH_L1;
      ST_FETCH_L1:  return ST_FETCH_L2;
      ST_FETCH_L2:  return ST_FETCH_L3;
      default:      return ST_DONE;
    endcase
  endfunction

  always_comb begin
    case (st)
      ST_FETCH_L1: cur_lvl = 2'd1;
      ST_FETCH_L2: cur_lvl = 2'd2;
      ST_FETCH_L3: cur_lvl = 2'd3;
      default:     cur_lvl = 2'd0;
    endcase
  end

  assign in_fetch  = (st == ST_FETCH_CTX) || (st == ST_FETCH_L1) ||
                     (st == ST_FETCH_L2)  || (st == ST_FETCH_L3);
  assign cmd_go    = in_fetch || (st == ST_UPDATE);
  assign cmd_write = (st == ST_UPDATE);

  pgw_memif #(.AW(PA_W), .DW(ENT_W)) memif_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_go(cmd_go), .cmd_write(cmd_write), .cmd_addr(addr_q), .cmd_wdata(leaf_q),
    .cmd_done(cmd_done), .cmd_rdata(rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  pgw_step step_i (
    .kind(entry_kind_e'(rdata[1:0])), .lvl(cur_lvl), .act(act), .ftype(ftype)
  );

  always_comb begin
    upd_ent = rdata;
    upd_ent[ACC_BIT] = 1'b1;
    if (wr_q) upd_ent[MOD_BIT] = 1'b1;
  end

  assign walk_accept   = req_valid && req_ready;
  assign walk_bypass   = walk_accept && !mmu_on;
  assign step_done     = in_fetch && cmd_done;
  assign step_leaf     = step_done && (act == ACT_LEAF);
  assign step_fault    = step_done && (act == ACT_FAULT);
  assign leaf_needs_wb = (upd_ent != rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      paddr_q <= '0;
      leaf_q  <= '0;
      lvl_q   <= '0;
      flt_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (walk_accept) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          leaf_q  <= '0;
          lvl_q   <= '0;
          flt_q   <= '0;
          if (mmu_on) begin
            paddr_q <= '0;
            addr_q  <= ctx_slot_addr(ctx_root, VA_W'(ctx_id));
            st      <= ST_FETCH_CTX;
          end else begin
            paddr_q <= PA_W'(req_vaddr);
            st      <= ST_DONE;
          end
        end
        ST_FETCH_CTX, ST_FETCH_L1, ST_FETCH_L2, ST_FETCH_L3: if (cmd_done) begin
          case (act)
            ACT_DESCEND: begin
              addr_q <= table_addr(rdata, va_q, cur_lvl + 2'd1);
              st     <= next_fetch(st);
            end
            ACT_LEAF: begin
              paddr_q <= leaf_paddr(rdata, va_q, cur_lvl);
              leaf_q  <= upd_ent;
              lvl_q   <= cur_lvl;
              st      <= leaf_needs_wb ? ST_UPDATE : ST_DONE;
            end
            default: begin
              flt_q <= fault_word(cur_lvl, ftype);
              st    <= ST_DONE;
            end
          endcase
        end
        ST_UPDATE: if (cmd_done) st <= ST_DONE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign done       = (st == ST_DONE);
  assign paddr      = paddr_q;
  assign leaf_entry = leaf_q;
  assign leaf_level = lvl_q;
  assign fault_code = flt_q;

  // R1: bypass finishes next cycle with the untranslated address
  a_r1_bypass_result: assert property (@(posedge clk) disable iff (!rst_n)
    walk_bypass |=> (done && paddr == PA_W'($past(req_vaddr)) && fault_code == '0));

  // R1: bypass touches no memory
  a_r1_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    walk_bypass |=> !mem_req_valid);

  // R5: a reported fault has a legal type and clear low bits
  a_r5_fault_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_code != '0) |->
      ((fault_code[4:2] == FT_INVALID || fault_code[4:2] == FT_XLATE) &&
       fault_code[1:0] == 2'b00 && fault_code[7:5] == 3'b000));

  // R6: a fault in the context entry always reports level 0
  a_r6_ctx_level: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fault && st == ST_FETCH_CTX) |=> (fault_code[9:8] == 2'd0));

  // R7: any written entry carries the accessed bit
  a_r7_wb_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[ACC_BIT]);

  // R8: write-back only follows a leaf without fault
  a_r8_wb_after_leaf: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (leaf_level != 2'd0 && fault_code == '0));

  // R10: done lasts one cycle and the walker is busy right after acceptance
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> !req_ready);
endmodule

// File: tb/pgw_top_tb_top.sv
module pgw_top_tb_top;
  typedef struct packed {
    logic        on;
    logic [7:0]  ctx;
    logic        wr;
    logic [31:0] va;
    logic [35:0] pa;
    logic [1:0]  lvl;
    logic [9:0]  flt;
    logic [2:0]  nrd;
    logic        wb;
    logic [31:0] leaf;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd2, 1'b0, 32'hCAFEBABE, 36'h0CAFEBABE, 2'd0, 10'h000, 3'd0, 1'b0, 32'h0},
    '{1'b1, 8'd2, 1'b0, 32'h01123456, 36'h123123456, 2'd1, 10'h000, 3'd2, 1'b1, 32'h12300022},
    '{1'b1, 8'd2, 1'b1, 32'h01000010, 36'h123000010, 2'd1, 10'h000, 3'd2, 1'b1, 32'h12300062},
    '{1'b1, 8'd2, 1'b1, 32'h00041234, 36'h00ABC1234, 2'd2, 10'h000, 3'd3, 1'b0, 32'h00ABC062},
    '{1'b1, 8'd2, 1'b0, 32'h00000ABC, 36'h00DEADABC, 2'd3, 10'h000, 3'd4, 1'b1, 32'h00DEAD22},
    '{1'b1, 8'd2, 1'b0, 32'h00001004, 36'h00BEEF004, 2'd3, 10'h000, 3'd4, 1'b0, 32'h00BEEF22},
    '{1'b1, 8'd2, 1'b1, 32'h00001FF0, 36'h00BEEFFF0, 2'd3, 10'h000, 3'd4, 1'b1, 32'h00BEEF62},
    '{1'b1, 8'd2, 1'b1, 32'h00001008, 36'h00BEEF008, 2'd3, 10'h000, 3'd4, 1'b0, 32'h00BEEF62},
    '{1'b1, 8'd3, 1'b0, 32'h00000000, 36'h0, 2'd0, 10'h004, 3'd1, 1'b0, 32'h0},
    '{1'b1, 8'd4, 1'b0, 32'h00000000, 36'h0, 2'd0, 10'h010, 3'd1, 1'b0, 32'h0},
    '{1'b1, 8'd5, 1'b1, 32'h00000000, 36'h0, 2'd0, 10'h010, 3'd1, 1'b0, 32'h0},
    '{1'b1, 8'd2, 1'b0, 32'h02000000, 36'h0, 2'd0, 10'h104, 3'd2, 1'b0, 32'h0},
    '{1'b1, 8'd2, 1'b0, 32'h03000000, 36'h0, 2'd0, 10'h110, 3'd2, 1'b0, 32'h0},
    '{1'b1, 8'd2, 1'b1, 32'h00080000, 36'h0, 2'd0, 10'h204, 3'd3, 1'b0, 32'h0},
    '{1'b1, 8'd2, 1'b0, 32'h000C0000, 36'h0, 2'd0, 10'h210, 3'd3, 1'b0, 32'h0},
    '{1'b1, 8'd2, 1'b0, 32'h00002000, 36'h0, 2'd0, 10'h304, 3'd4, 1'b0, 32'h0},
    '{1'b1, 8'd2, 1'b0, 32'h00003000, 36'h0, 2'd0, 10'h310, 3'd4, 1'b0, 32'h0},
    '{1'b1, 8'd2, 1'b1, 32'h00004000, 36'h0, 2'd0, 10'h310, 3'd4, 1'b0, 32'h0}
  };

  localparam logic [31:0] ROOT = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, mmu_on = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] ctx_root = ROOT;
  logic [7:0]  ctx_id = '0;
  logic        req_ready, done;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready, mem_rsp_valid;
  logic [35:0] mem_req_addr, paddr;
  logic [31:0] mem_req_wdata, mem_rsp_data, leaf_entry;
  logic [1:0]  leaf_level;
  logic [9:0]  fault_code;

  int checks = 0, fails = 0;
  logic [31:0] mem [logic [35:0]];
  logic [35:0] rd_log [8];
  int nrd = 0, nwb = 0, overlap = 0, hold_bad = 0, busy_bad = 0;
  logic [35:0] wb_addr;
  logic [31:0] wb_data;

  always #5 clk = ~clk;

  pgw_top #(.CTX_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .mmu_on(mmu_on),
    .ctx_root(ctx_root), .ctx_id(ctx_id),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .paddr(paddr),
    .leaf_entry(leaf_entry), .leaf_level(leaf_level), .fault_code(fault_code)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // memory model: answers a read one cycle after acceptance, stalls on a cadence
  initial begin
    logic        rd_acc;
    logic [31:0] rd_q;
    logic        stall_prev;
    logic [35:0] prev_addr;
    int cyc;
    rd_acc = 0; rd_q = '0; stall_prev = 0; prev_addr = '0; cyc = 0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rd_acc) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = rd_q; rd_acc = 0;
        if (mem_req_valid) overlap++;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      if (stall_prev && !(mem_req_valid && mem_req_addr == prev_addr)) hold_bad++;
      mem_req_ready = (cyc % 3) != 1;
      if (mem_req_valid && mem_req_ready) begin
        stall_prev = 0;
        if (mem_req_write) begin
          mem[mem_req_addr] = mem_req_wdata;
          nwb++; wb_addr = mem_req_addr; wb_data = mem_req_wdata;
        end else begin
          rd_acc = 1;
          rd_q = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
          if (nrd < 8) rd_log[nrd] = mem_req_addr;
          nrd++;
        end
      end else begin
        stall_prev = mem_req_valid;
        prev_addr  = mem_req_addr;
      end
    end
  end

  task automatic run_vec(input vec_t v, input int idx);
    int waited;
    logic [35:0] first;
    @(negedge clk);
    nrd = 0; nwb = 0;
    mmu_on = v.on; ctx_id = v.ctx; req_vaddr = v.va; req_write = v.wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 1000) begin
      if (req_ready) busy_bad++;
      @(negedge clk);
      waited++;
    end
    chk(done, "R10", $sformatf("vec %0d completes", idx), 64'(done), 64'd1);
    if (req_ready) busy_bad++;
    // R5 / R6 fault code, R4 / R1 result
    chk(fault_code == v.flt, (v.flt[4:2] == 3'd4) ? "R6" : "R5",
        $sformatf("vec %0d fault_code", idx), 64'(fault_code), 64'(v.flt));
    if (v.flt == '0) begin
      chk(paddr == v.pa, v.on ? "R4" : "R1", $sformatf("vec %0d paddr", idx), 64'(paddr), 64'(v.pa));
      chk(leaf_level == v.lvl, v.on ? "R4" : "R1", $sformatf("vec %0d leaf_level", idx),
          64'(leaf_level), 64'(v.lvl));
      if (v.on) chk(leaf_entry == v.leaf, "R7", $sformatf("vec %0d leaf_entry", idx),
                    64'(leaf_entry), 64'(v.leaf));
    end
    // R3 walk depth
    chk(nrd == int'(v.nrd), "R3", $sformatf("vec %0d read count", idx), 64'(nrd), 64'(v.nrd));
    if (v.nrd != 0) begin
      first = {ROOT, 4'b0000} + 36'(v.ctx) * 36'd4;
      chk(rd_log[0] == first, "R2", $sformatf("vec %0d first read", idx), 64'(rd_log[0]), 64'(first));
    end
    // R8 write-back presence, R7 contents and place
    chk(nwb == int'(v.wb), "R8", $sformatf("vec %0d write-back count", idx), 64'(nwb), 64'(v.wb));
    if (v.wb && nwb == 1) begin
      chk(wb_data == v.leaf, "R7", $sformatf("vec %0d write-back data", idx), 64'(wb_data), 64'(v.leaf));
      chk(wb_addr == rd_log[v.nrd - 1], "R7", $sformatf("vec %0d write-back addr", idx),
          64'(wb_addr), 64'(rd_log[v.nrd - 1]));
    end
    @(negedge clk);
    chk(!done && req_ready, "R10", $sformatf("vec %0d done pulse ends", idx),
        64'({done, req_ready}), 64'b01);
  endtask

  initial begin
    mem[36'h10008] = 32'h00002001;
    mem[36'h10010] = 32'h00000002;
    mem[36'h10014] = 32'h00000003;
    mem[36'h20000] = 32'h00003001;
    mem[36'h20004] = 32'h12300002;
    mem[36'h2000C] = 32'h00000003;
    mem[36'h30000] = 32'h00004001;
    mem[36'h30004] = 32'h00ABC062;
    mem[36'h3000C] = 32'h00000003;
    mem[36'h40000] = 32'h00DEAD02;
    mem[36'h40004] = 32'h00BEEF22;
    mem[36'h4000C] = 32'h00005001;
    mem[36'h40010] = 32'h00000003;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready && !done && !mem_req_valid, "R11", "reset outputs",
        64'({req_ready, done, mem_req_valid}), 64'b100);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R3 full read sequence of the 4 KB walk (vector 4 repeated, leaf now marked)
    run_vec('{1'b1, 8'd2, 1'b0, 32'h00000ABC, 36'h00DEADABC, 2'd3, 10'h000, 3'd4, 1'b0, 32'h00DEAD22}, 99);
    chk(rd_log[1] == 36'h20000 && rd_log[2] == 36'h30000 && rd_log[3] == 36'h40000, "R3",
        "descriptor read addresses", 64'(rd_log[3]), 64'h40000);

    // R10 results hold while idle
    repeat (3) @(negedge clk);
    chk(paddr == 36'h00DEADABC && leaf_level == 2'd3 && req_ready, "R10", "results held while idle",
        64'(paddr), 64'h00DEADABC);

    // R9 memory handshake rules seen by the model
    chk(hold_bad == 0, "R9", "stalled request held", 64'(hold_bad), 64'd0);
    chk(overlap == 0, "R9", "single outstanding read", 64'(overlap), 64'd0);
    chk(busy_bad == 0, "R10", "req_ready low while busy", 64'(busy_bad), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule